// File: doc/BRIEF.md
# Firmware Health Status Checker

This block sits on the host side of a link to a device that carries an embedded microcontroller. Before the host turns on accesses that depend on that firmware, the block decides whether the firmware is loaded and alive. It makes single-byte register reads through a generic read port with a request/response handshake. Only one read is in flight at a time.

A pulse on `start_i` begins one check. The block first reads the code-load status byte and judges it against a minimum value. It then takes one reference sample of the heartbeat byte and re-reads that byte up to a bounded number of times, looking for any change. When the sequence ends, the block updates `load_ok_o` and `heartbeat_ok_o`. If both pass, it compares the firmware version on its inputs against a minimum version key and drives `feature_en_o` from the result. `done_o` pulses when the sequence ends, whether it ends normally or not. If a read response carries an error, the sequence stops at once and `error_o` is raised together with `done_o`.

Top module: `fw_health_chk`

## Requirements
- R1: After reset, `load_ok_o`, `heartbeat_ok_o`, `feature_en_o`, `done_o`, `error_o`, `busy_o` and `rd_req_valid_o` are all low.
- R2: A `start_i` pulse while idle makes the first request go to address `LOAD_ADDR` (default 0x605). A request holds `rd_req_valid_o` high with a stable address until `rd_req_ready_i` is seen. No new request is raised until the response to the previous one has arrived.
- R3: The load check passes when the status byte, read as unsigned, is at least `LOAD_MIN` (default 0x0E). So 0x0D fails, and 0x0E and 0xFF pass.
- R4: After the load read come one reference read and then up to `HB_TRIES` (default 100) re-reads, all at address `HB_ADDR` (default 0x923).
- R5: The first re-read whose byte differs from the reference ends the sequence with `heartbeat_ok_o` high. No further reads follow.
- R6: If all `HB_TRIES` re-reads equal the reference, `heartbeat_ok_o` becomes low, after exactly `HB_TRIES`+1 heartbeat reads.
- R7: `feature_en_o` is high when the 32-bit key {major, minor, build_hi, build_lo} is greater than or equal to the parameter `VER_MIN`. The build number is little-endian: `ver_build_lo_i` is its low byte.
- R8: If the load check or the heartbeat check fails, the version is taken as zero. With a non-zero `VER_MIN`, `feature_en_o` is then low whatever the version inputs are.
- R9: An error response aborts the sequence at once. `done_o` and `error_o` are high in the same cycle, no further request is made, and the three flags keep their previous values.
- R10: A `start_i` pulse while `busy_o` is high has no effect. The running sequence makes the same reads and produces a single `done_o`.
- R11: `done_o` is a one-cycle pulse. On a normal end the three flags update at the same clock edge that raises `done_o`, and they hold until the next sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one check sequence (ignored while busy) |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | ADDR_W | Read register address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 8 | Read response byte |
| rd_rsp_err_i | input | 1 | Read response error |
| ver_major_i | input | 8 | Firmware major version |
| ver_minor_i | input | 8 | Firmware minor version |
| ver_build_lo_i | input | 8 | Firmware build number, low byte |
| ver_build_hi_i | input | 8 | Firmware build number, high byte |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| error_o | output | 1 | High with done_o when the sequence aborted |
| load_ok_o | output | 1 | Code-load check passed |
| heartbeat_ok_o | output | 1 | Heartbeat change observed |
| feature_en_o | output | 1 | Version at or above the minimum, with both checks passed |

## Verification
On the last allowed re-read, two outcomes of the heartbeat loop compete in the same response cycle: a change of the byte and the exhaustion of the try limit. The bench provokes this by making the byte differ only on re-read number `HB_TRIES` and expects a pass, with no further read. The same final response cycle can also carry an error. The bench places the error on that last re-read and expects an abort, with the flags left as the previous run set them.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_HREF, PH_HRUN} phase_e;
  typedef enum logic [1:0] {RP_IDLE, RP_REQ, RP_WAIT} rp_state_e;
endpackage

// File: rtl/fwh_rd_port.sv
module fwh_rd_port #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [7:0]        rsp_data_i,
  input  logic              rsp_err_i,
  output logic              ack_o,
  output logic [7:0]        data_o,
  output logic              err_o
);
  import fwh_pkg::*;

  rp_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;

  assign ack_o       = (st_q == RP_WAIT) && rsp_valid_i;
  assign data_o      = rsp_data_i;
  assign err_o       = rsp_err_i;
  assign req_valid_o = (st_q == RP_REQ);
  assign req_addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RP_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        RP_IDLE: if (go_i) begin
          st_q   <= RP_REQ;
          addr_q <= addr_i;
        end
        RP_REQ: if (req_ready_i) st_q <= RP_WAIT;
        RP_WAIT: if (rsp_valid_i) begin
          // back-to-back launch allowed in the response cycle
          st_q <= go_i ? RP_REQ : RP_IDLE;
          if (go_i) addr_q <= addr_i;
        end
        default: st_q <= RP_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  // R2
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (st_q == RP_IDLE) || ack_o);
endmodule

// File: rtl/fwh_ver_cmp.sv
module fwh_ver_cmp #(
  parameter logic [31:0] VER_MIN = 32'h0202_0000
) (
  input  logic       gate_i,
  input  logic [7:0] major_i,
  input  logic [7:0] minor_i,
  input  logic [7:0] build_lo_i,
  input  logic [7:0] build_hi_i,
  output logic       ge_o
);
  logic [31:0] key;

  // failed health checks force a zero version
  assign key  = gate_i ? {major_i, minor_i, build_hi_i, build_lo_i} : 32'h0;
  assign ge_o = (key >= VER_MIN);
endmodule

// File: rtl/fwh_seq.sv
module fwh_seq #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] LOAD_ADDR = 16'h0605,
  parameter logic [15:0] HB_ADDR   = 16'h0923,
  parameter logic [7:0]  LOAD_MIN  = 8'h0E,
  parameter int          HB_TRIES  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic [7:0]        data_i,
  input  logic              err_i,
  input  logic              ver_ge_i,
  output logic              go_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              gate_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              load_ok_o,
  output logic              hb_ok_o,
  output logic              feat_en_o
);
  import fwh_pkg::*;

  localparam int CNT_W = (HB_TRIES > 1) ? $clog2(HB_TRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HB_TRIES - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       ref_q;
  logic             load_q;
  logic             hb_moved;
  logic             cnt_end;

  assign hb_moved = (data_i != ref_q);
  assign cnt_end  = (cnt_q == CNT_LAST);
  assign busy_o   = (ph_q != PH_IDLE);
  assign gate_o   = load_q && hb_moved;
  assign addr_o   = (ph_q == PH_IDLE) ? ADDR_W'(LOAD_ADDR) : ADDR_W'(HB_ADDR);

  always_comb begin
    go_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: go_o = start_i;
      PH_LOAD,
      PH_HREF: go_o = ack_i && !err_i;
      PH_HRUN: go_o = ack_i && !err_i && !hb_moved && !cnt_end;
      default: go_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      ref_q     <= '0;
      load_q    <= 1'b0;
      done_o    <= 1'b0;
      error_o   <= 1'b0;
      load_ok_o <= 1'b0;
      hb_ok_o   <= 1'b0;
      feat_en_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      error_o <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) ph_q <= PH_LOAD;
        PH_LOAD: if (ack_i) begin
          if (err_i) begin
            ph_q <= PH_IDLE; done_o <= 1'b1; error_o <= 1'b1;
          end else begin
            load_q <= (data_i >= LOAD_MIN);
            ph_q   <= PH_HREF;
          end
        end
        PH_HREF: if (ack_i) begin
          if (err_i) begin
            ph_q <= PH_IDLE; done_o <= 1'b1; error_o <= 1'b1;
          end else begin
            ref_q <= data_i;
            cnt_q <= '0;
            ph_q  <= PH_HRUN;
          end
        end
        PH_HRUN: if (ack_i) begin
          if (err_i) begin
            ph_q <= PH_IDLE; done_o <= 1'b1; error_o <= 1'b1;
          end else if (hb_moved || cnt_end) begin
            // a change on the last try still counts as a pass
            ph_q      <= PH_IDLE;
            done_o    <= 1'b1;
            load_ok_o <= load_q;
            hb_ok_o   <= hb_moved;
            feat_en_o <= ver_ge_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  // R9
  err_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> $stable(load_ok_o) && $stable(hb_ok_o) && $stable(feat_en_o));

  // R11
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(load_ok_o) && $stable(hb_ok_o) && $stable(feat_en_o));

  // R6
  try_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HRUN) |-> (cnt_q <= CNT_LAST));

  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !ack_i |=> $stable(cnt_q) && busy_o);
endmodule

// File: rtl/fw_health_chk.sv
module fw_health_chk #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] LOAD_ADDR = 16'h0605,
  parameter logic [15:0] HB_ADDR   = 16'h0923,
  parameter logic [7:0]  LOAD_MIN  = 8'h0E,
  parameter int          HB_TRIES  = 100,
  parameter logic [31:0] VER_MIN   = 32'h0202_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [7:0]        rd_rsp_data_i,
  input  logic              rd_rsp_err_i,
  input  logic [7:0]        ver_major_i,
  input  logic [7:0]        ver_minor_i,
  input  logic [7:0]        ver_build_lo_i,
  input  logic [7:0]        ver_build_hi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              load_ok_o,
  output logic              heartbeat_ok_o,
  output logic              feature_en_o
);
  logic              go;
  logic [ADDR_W-1:0] go_addr;
  logic              ack;
  logic [7:0]        rsp_byte;
  logic              rsp_bad;
  logic              gate;
  logic              ver_ge;

  fwh_rd_port #(.ADDR_W(ADDR_W)) i_rd_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .addr_i      (go_addr),
    .req_valid_o (rd_req_valid_o),
    .req_ready_i (rd_req_ready_i),
    .req_addr_o  (rd_req_addr_o),
    .rsp_valid_i (rd_rsp_valid_i),
    .rsp_data_i  (rd_rsp_data_i),
    .rsp_err_i   (rd_rsp_err_i),
    .ack_o       (ack),
    .data_o      (rsp_byte),
    .err_o       (rsp_bad)
  );

  fwh_seq #(
    .ADDR_W    (ADDR_W),
    .LOAD_ADDR (LOAD_ADDR),
    .HB_ADDR   (HB_ADDR),
    .LOAD_MIN  (LOAD_MIN),
    .HB_TRIES  (HB_TRIES)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ack_i     (ack),
    .data_i    (rsp_byte),
    .err_i     (rsp_bad),
    .ver_ge_i  (ver_ge),
    .go_o      (go),
    .addr_o    (go_addr),
    .gate_o    (gate),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .error_o   (error_o),
    .load_ok_o (load_ok_o),
    .hb_ok_o   (heartbeat_ok_o),
    .feat_en_o (feature_en_o)
  );

  fwh_ver_cmp #(.VER_MIN(VER_MIN)) i_ver_cmp (
    .gate_i     (gate),
    .major_i    (ver_major_i),
    .minor_i    (ver_minor_i),
    .build_lo_i (ver_build_lo_i),
    .build_hi_i (ver_build_hi_i),
    .ge_o       (ver_ge)
  );

  // R2
  req_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o |-> busy_o);

  // R8
  feat_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feature_en_o |-> (load_ok_o && heartbeat_ok_o) || (VER_MIN == 32'h0));
endmodule

// File: tb/test_fw_health_chk.sv
module test_fw_health_chk;
  localparam logic [31:0] THR = 32'h0202_0100;
  localparam int TRIES = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req_valid, req_ready = 1'b0;
  logic [15:0] req_addr;
  logic rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [7:0] rsp_data = 8'h0;
  logic [7:0] v_maj = 0, v_min = 0, v_lo = 0, v_hi = 0;
  logic busy, done, error, load_ok, hb_ok, feat_en;

  always #5 clk = ~clk;

  fw_health_chk #(.VER_MIN(THR), .HB_TRIES(TRIES)) i_fw_health_chk (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rd_req_valid_o(req_valid), .rd_req_ready_i(req_ready), .rd_req_addr_o(req_addr),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data), .rd_rsp_err_i(rsp_err),
    .ver_major_i(v_maj), .ver_minor_i(v_min), .ver_build_lo_i(v_lo), .ver_build_hi_i(v_hi),
    .busy_o(busy), .done_o(done), .error_o(error),
    .load_ok_o(load_ok), .heartbeat_ok_o(hb_ok), .feature_en_o(feat_en)
  );

  typedef struct {bit err; bit ld; bit hb; bit fe;} exp_t;
  exp_t sb_q[$];

  int total = 0, bad = 0, ndone = 0, rd_idx = 0, cyc = 0;
  int s_load = 0, s_chg = -1, s_err = -1;
  logic [7:0] s_ref = 8'h5A;
  bit m_ld = 0, m_hb = 0, m_fe = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk("watchdog", 1, 0);
        finish_run();
      end
    end
  end

  // responder: one read at a time, variable ready delay
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic [15:0] a;
        int d;
        a = req_addr;
        // R2 / R4 address order
        chk(rd_idx == 0 ? "R2 load addr" : "R4 hb addr", a, rd_idx == 0 ? 16'h0605 : 16'h0923);
        d = rd_idx % 3;
        for (int k = 0; k < d; k++) begin
          @(negedge clk);
          if (!req_valid || req_addr != a) chk("R2 request hold", 0, 1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (req_valid) chk("R2 outstanding", 1, 0);
        rsp_valid = 1'b1;
        rsp_err   = (rd_idx == s_err);
        if (rd_idx == 0) rsp_data = 8'(s_load);
        else if (rd_idx == 1) rsp_data = s_ref;
        else rsp_data = ((rd_idx - 2) == s_chg) ? s_ref + 8'd1 : s_ref;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rd_idx++;
      end
    end
  end

  // monitor: pop expected result at each done
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb_q.size() == 0) chk("R10 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R9 error flag", error, e.err);
          chk("R3 load_ok", load_ok, e.ld);
          chk("R5/R6 heartbeat_ok", hb_ok, e.hb);
          chk("R7/R8 feature_en", feat_en, e.fe);
        end
        ndone++;
      end else if (error) chk("R9 error without done", 1, 0);
    end
  end

  task automatic run(input int ld_byte, input int chg, input int erri,
                     input logic [7:0] maj, input logic [7:0] mn,
                     input logic [7:0] lo, input logic [7:0] hi, input bit restart);
    exp_t e;
    int exp_reads, n0;
    bit ld, hb;
    logic [31:0] key;
    ld  = (ld_byte >= 8'h0E);
    hb  = (chg >= 0);
    key = (ld && hb) ? {maj, mn, hi, lo} : 32'h0;
    exp_reads = 2 + (hb ? chg + 1 : TRIES);
    if (erri >= 0 && erri < exp_reads) begin
      exp_reads = erri + 1;
      e = '{err: 1, ld: m_ld, hb: m_hb, fe: m_fe};
    end else begin
      m_ld = ld; m_hb = hb; m_fe = (key >= THR);
      e = '{err: 0, ld: m_ld, hb: m_hb, fe: m_fe};
    end
    sb_q.push_back(e);
    s_load = ld_byte; s_chg = chg; s_err = erri; s_ref = s_ref + 8'd17;
    v_maj = maj; v_min = mn; v_lo = lo; v_hi = hi;
    rd_idx = 0;
    n0 = ndone;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (20) @(negedge clk);
      // R10 start while busy must be ignored
      chk("R10 busy before restart", busy, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (ndone == n0 + 1);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    chk("R11 load_ok held", load_ok, e.ld);
    repeat (8) @(negedge clk);
    // R5 / R9 no extra reads after end
    chk("R5/R6/R9 read count", rd_idx, exp_reads);
    chk("R10 single done", ndone, n0 + 1);
    chk("R11 feature held", feat_en, e.fe);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 load_ok", load_ok, 0);
    chk("R1 hb_ok", hb_ok, 0);
    chk("R1 feature", feat_en, 0);
    chk("R1 done", done, 0);
    chk("R1 error", error, 0);
    chk("R1 req", req_valid, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {27'b0, load_ok, hb_ok, feat_en, done, req_valid}, 0);

    run(8'h0E, 0, -1, 8'd2, 8'd2, 8'h00, 8'h01, 0);   // R3 boundary, R7 equal key
    run(8'h0D, 5, -1, 8'd3, 8'd0, 8'h00, 8'h00, 0);   // R3 fail, R8 gate
    run(8'hFF, -1, -1, 8'd9, 8'd9, 8'h00, 8'h00, 0);  // R6 no change, R8
    run(8'h0E, TRIES - 1, -1, 8'd2, 8'd2, 8'h01, 8'h00, 0); // R5 last try, R7 little-endian below
    run(8'h20, 3, -1, 8'd2, 8'd2, 8'h00, 8'h01, 0);   // R7 pass
    run(8'h20, 3, 0, 8'd0, 8'd0, 8'h00, 8'h00, 0);    // R9 error on load read
    run(8'h20, -1, 1 + TRIES, 8'd0, 8'd0, 8'h00, 8'h00, 0); // R9 error on last re-read
    run(8'h20, 4, 1, 8'd0, 8'd0, 8'h00, 8'h00, 0);    // R9 error on reference read
    run(8'h30, 10, -1, 8'd2, 8'd1, 8'hFF, 8'hFF, 1);  // R10 restart ignored, R7 below
    run(8'h30, 7, -1, 8'd3, 8'd0, 8'h00, 8'h00, 0);   // R7 higher major
    run(8'h30, 2, -1, 8'd1, 8'd255, 8'hFF, 8'hFF, 0); // R7 lower major
    finish_run();
  end
endmodule